// File: doc/BRIEF.md
# Audio Peak Programme Level Meter

This block turns a stream of stereo PCM sample pairs into bar-graph frames for a strip of eight RGB LEDs. Each sample is rectified per channel and only the louder channel is kept. The magnitudes feed a boxcar average over a 480-sample window, which is 10 ms at a 48 kHz sample rate. The smoothed level is picked off once every 32 samples. A peak-hold stage follows. It jumps to any higher level at once and otherwise falls back linearly, reaching zero from full scale in about 2.5 s. The held level is compared with a ladder of thresholds, and one packet of addressed colour beats goes out per update.

The window is kept as a running sum and is never divided. Thresholds and decay live in the same summed scale, where the full-scale average of 32767 equals 15,728,160. The sample input never stalls. The frame output follows a valid/ready handshake. When the frame output is held off, only the newest level waits to be sent.

Top module: `ppm_meter`

## Requirements
- R1: `in_ready` is high in every cycle after reset, and each cycle with `in_valid` high delivers one sample pair.
- R2: A channel's magnitude is its absolute value, except that -32768 gives 32767. The magnitude is always 15 bits wide.
- R3: Only the larger of the two channel magnitudes enters the window.
- R4: The window level is the sum of the most recent 480 magnitudes, with older ones counting as zero. A level update happens after every 32nd accepted sample, and each update yields exactly one packet when `out_ready` stays high.
- R5: On an update, the held level becomes the larger of two values: the window sum, and the previous held level minus 4194 (floored at zero).
- R6: LED k (k = 0..7) is lit when the held level is at least (k+1) x 1,900,800, which is a window average of (k+1) x 3960. A level exactly on a threshold lights that LED.
- R7: An unlit LED is black (0,0,0). Lit LEDs 0..5 are green (0x00,0x40,0x00), lit LED 6 is amber (0x40,0x20,0x00) and lit LED 7 is red (0x40,0x00,0x00), given as (red, green, blue).
- R8: A packet has eight beats with addresses 0 to 7 in order, and `out_last` is high only on the beat with address 7.
- R9: While `out_valid` is high and `out_ready` is low, every output holds its value. Updates that arrive while a packet is waiting replace it, so after the stall ends only the newest level is sent next.
- R10: After reset, `out_valid` is low and both the window and the held level are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair present |
| in_ready | output | 1 | Always high: samples are never refused |
| in_left | input | 16 | Left sample, two's complement |
| in_right | input | 16 | Right sample, two's complement |
| out_valid | output | 1 | LED beat present |
| out_ready | input | 1 | Downstream accepts the beat |
| out_addr | output | 8 | LED index within the packet |
| out_red | output | 8 | Red value |
| out_green | output | 8 | Green value |
| out_blue | output | 8 | Blue value |
| out_last | output | 1 | Final beat of the packet |

## Verification
The bench starts with -32768 on one channel for a full window. A design that drops the saturation wraps that value to a zero magnitude and shows an empty bar instead of a full red-topped one. It drives a constant average of exactly 3960, and of 3959, to probe the first threshold. An off-by-one compare lights the LED at 3959 or leaves it dark at 3960. It runs a long silence after full scale and then a loud burst. A wrong decay step or a missed rise gives a different lit count than the one computed from the step size. Last, it holds the output stalled across ten updates. A design that queues stale levels, or that lets the stuck beat change, sends the wrong second packet.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  localparam logic [7:0] LED_FULL = 8'h40;
  localparam logic [7:0] LED_HALF = 8'h20;

  // colour of one bar segment: top is red, next down amber, rest green
  function automatic rgb_t led_colour(input logic lit, input int unsigned idx,
                                      input int unsigned n);
    rgb_t c;
    c = '0;
    if (lit) begin
      if (idx == n - 1) begin
        c.r = LED_FULL;
      end else if (idx == n - 2) begin
        c.r = LED_FULL;
        c.g = LED_HALF;
      end else begin
        c.g = LED_FULL;
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/ppm_boxcar.sv
module ppm_boxcar #(
  parameter int SAMPLE_W = 16,
  parameter int WIN_LEN  = 480,
  parameter int DECIM    = 32,
  parameter int MAG_W    = SAMPLE_W - 1,
  parameter int SUM_W    = MAG_W + $clog2(WIN_LEN + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_left,
  input  logic signed [SAMPLE_W-1:0] smp_right,
  output logic [MAG_W-1:0]           smp_mag,
  output logic [SUM_W-1:0]           win_sum,
  output logic                       dec_tick
);

  localparam int PTR_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int CNT_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  // absolute value, most negative code clamps to the largest magnitude
  function automatic logic [MAG_W-1:0] sat_abs(input logic signed [SAMPLE_W-1:0] x);
    logic [SAMPLE_W-1:0] n;
    if (!x[SAMPLE_W-1]) return x[MAG_W-1:0];
    if (x == MOST_NEG) return '1;
    n = -x;
    return n[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0] hist [WIN_LEN];
  logic [PTR_W-1:0] wr_ptr;
  logic [CNT_W-1:0] dec_cnt;
  logic [MAG_W-1:0] mag_l, mag_r, oldest;

  assign mag_l   = sat_abs(smp_left);
  assign mag_r   = sat_abs(smp_right);
  assign smp_mag = (mag_l > mag_r) ? mag_l : mag_r;
  assign oldest  = hist[wr_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_LEN; i++) hist[i] <= '0;
      wr_ptr   <= '0;
      dec_cnt  <= '0;
      win_sum  <= '0;
      dec_tick <= 1'b0;
    end else begin
      dec_tick <= 1'b0;
      if (smp_valid) begin
        hist[wr_ptr] <= smp_mag;
        win_sum      <= win_sum + SUM_W'(smp_mag) - SUM_W'(oldest);
        wr_ptr       <= (wr_ptr == PTR_W'(WIN_LEN - 1)) ? '0 : wr_ptr + 1'b1;
        if (dec_cnt == CNT_W'(DECIM - 1)) begin
          dec_cnt  <= '0;
          dec_tick <= 1'b1;
        end else begin
          dec_cnt <= dec_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ppm_peak.sv
module ppm_peak #(
  parameter int SUM_W      = 24,
  parameter int DECAY_STEP = 4194
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_tick,
  input  logic [SUM_W-1:0] win_sum,
  output logic [SUM_W-1:0] peak_lvl,
  output logic             peak_upd
);

  localparam logic [SUM_W-1:0] STEP = SUM_W'(DECAY_STEP);

  function automatic logic [SUM_W-1:0] hold_next(input logic [SUM_W-1:0] held,
                                                 input logic [SUM_W-1:0] fresh);
    logic [SUM_W-1:0] fallen;
    fallen = (held > STEP) ? held - STEP : '0;
    return (fresh > fallen) ? fresh : fallen;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak_lvl <= '0;
      peak_upd <= 1'b0;
    end else begin
      peak_upd <= dec_tick;
      if (dec_tick) peak_lvl <= hold_next(peak_lvl, win_sum);
    end
  end

endmodule

// File: rtl/ppm_bar_tx.sv
module ppm_bar_tx
  import ppm_pkg::*;
#(
  parameter int SUM_W    = 24,
  parameter int N_LEDS   = 8,
  parameter int THR_STEP = 1900800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_upd,
  input  logic [SUM_W-1:0] lvl,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_addr,
  output rgb_t             out_rgb,
  output logic             out_last
);

  localparam int IDX_W = (N_LEDS > 1) ? $clog2(N_LEDS) : 1;

  function automatic logic [SUM_W-1:0] thr_of(input int k);
    return SUM_W'(longint'(THR_STEP) * longint'(k + 1));
  endfunction

  logic             pend, busy;
  logic [SUM_W-1:0] pend_lvl, cur_lvl;
  logic [IDX_W-1:0] idx;
  logic [N_LEDS-1:0] lit_vec;

  for (genvar g = 0; g < N_LEDS; g++) begin : g_cmp
    assign lit_vec[g] = (cur_lvl >= thr_of(g));
  end

  assign out_valid = busy;
  assign out_addr  = 8'(idx);
  assign out_last  = busy && (idx == IDX_W'(N_LEDS - 1));
  assign out_rgb   = led_colour(lit_vec[idx], 32'(idx), 32'(N_LEDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      busy     <= 1'b0;
      pend_lvl <= '0;
      cur_lvl  <= '0;
      idx      <= '0;
    end else begin
      if (busy && out_ready) begin
        if (idx == IDX_W'(N_LEDS - 1)) busy <= 1'b0;
        else idx <= idx + 1'b1;
      end
      if (!busy && pend) begin
        busy    <= 1'b1;
        idx     <= '0;
        cur_lvl <= pend_lvl;
        pend    <= 1'b0;
      end
      if (lvl_upd) begin
        pend     <= 1'b1;
        pend_lvl <= lvl;
      end
    end
  end

endmodule

// File: rtl/ppm_meter.sv
module ppm_meter
  import ppm_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int WIN_LEN    = 480,
  parameter int DECIM      = 32,
  parameter int N_LEDS     = 8,
  parameter int DECAY_STEP = 4194,
  parameter int THR_STEP   = 1900800
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [7:0]                 out_addr,
  output logic [7:0]                 out_red,
  output logic [7:0]                 out_green,
  output logic [7:0]                 out_blue,
  output logic                       out_last
);

  localparam int MAG_W = SAMPLE_W - 1;
  localparam int SUM_W = MAG_W + $clog2(WIN_LEN + 1);

  logic [MAG_W-1:0] smp_mag;
  logic [SUM_W-1:0] win_sum, peak_lvl;
  logic             dec_tick, peak_upd;
  rgb_t             beat_rgb;

  assign in_ready = rst_n;

  ppm_boxcar #(
    .SAMPLE_W(SAMPLE_W), .WIN_LEN(WIN_LEN), .DECIM(DECIM),
    .MAG_W(MAG_W), .SUM_W(SUM_W)
  ) u_box (
    .clk(clk), .rst_n(rst_n), .smp_valid(in_valid),
    .smp_left(in_left), .smp_right(in_right),
    .smp_mag(smp_mag), .win_sum(win_sum), .dec_tick(dec_tick)
  );

  ppm_peak #(.SUM_W(SUM_W), .DECAY_STEP(DECAY_STEP)) u_peak (
    .clk(clk), .rst_n(rst_n), .dec_tick(dec_tick), .win_sum(win_sum),
    .peak_lvl(peak_lvl), .peak_upd(peak_upd)
  );

  ppm_bar_tx #(.SUM_W(SUM_W), .N_LEDS(N_LEDS), .THR_STEP(THR_STEP)) u_bar (
    .clk(clk), .rst_n(rst_n), .lvl_upd(peak_upd), .lvl(peak_lvl),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_rgb(beat_rgb), .out_last(out_last)
  );

  assign out_red   = beat_rgb.r;
  assign out_green = beat_rgb.g;
  assign out_blue  = beat_rgb.b;

endmodule

// File: rtl/ppm_meter_sva.sv
module ppm_meter_sva #(
  parameter int SUM_W      = 24,
  parameter int WIN_LEN    = 480,
  parameter int MAG_W      = 15,
  parameter int N_LEDS     = 8,
  parameter int DECAY_STEP = 4194
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_addr,
  input logic [7:0]       out_red,
  input logic [7:0]       out_green,
  input logic [7:0]       out_blue,
  input logic             out_last,
  input logic [SUM_W-1:0] win_sum,
  input logic [SUM_W-1:0] peak_lvl,
  input logic             dec_tick
);

  localparam longint MAX_SUM = longint'(WIN_LEN) * ((longint'(1) << MAG_W) - 1);

  a_r1_always_ready: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  a_r4_sum_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(win_sum) <= MAX_SUM);

  a_r5_rise_now: assert property (@(posedge clk) disable iff (!rst_n)
    dec_tick |=> peak_lvl >= $past(win_sum));

  a_r5_decay_limit: assert property (@(posedge clk) disable iff (!rst_n)
    dec_tick |=> (longint'(peak_lvl) + DECAY_STEP) >= longint'($past(peak_lvl)));

  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_tick |=> $stable(peak_lvl));

  a_r8_last_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> out_addr == 8'(N_LEDS - 1));

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid && out_addr == $past(out_addr) + 8'd1);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_addr) && $stable(out_red)
      && $stable(out_green) && $stable(out_blue) && $stable(out_last));

endmodule

bind ppm_meter ppm_meter_sva #(
  .SUM_W(SUM_W), .WIN_LEN(WIN_LEN), .MAG_W(MAG_W), .N_LEDS(N_LEDS),
  .DECAY_STEP(DECAY_STEP)
) u_sva (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_red(out_red),
  .out_green(out_green), .out_blue(out_blue), .out_last(out_last),
  .win_sum(win_sum), .peak_lvl(peak_lvl), .dec_tick(dec_tick)
);

// File: tb/sim_ppm_meter.sv
module sim_ppm_meter;
  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 480;
  localparam int DEC  = 32;
  localparam int NL   = 8;
  localparam longint STEP = 4194;
  localparam longint THR  = 1900800;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic signed [15:0] in_left = '0, in_right = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_addr, out_red, out_green, out_blue;

  ppm_meter u0 (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit cmp_en = 1'b1;
  int exp_q[$];
  int got_q[$];

  int unsigned mh[WIN];
  int wp = 0, mc = 0;
  longint msum = 0, mpeak = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int lit_of(input longint lv);
    int c = 0;
    for (int k = 0; k < NL; k++) if (lv >= THR * (k + 1)) c++;
    return c;
  endfunction

  function automatic int unsigned bmag(input int v);
    if (v >= 0) return v;
    if (-v > 32767) return 32767;
    return -v;
  endfunction

  // reference chain from the requirements (R2..R6)
  task automatic model_push(input int l, input int r);
    int unsigned a = bmag(l), b = bmag(r), m;
    longint fallen;
    m = (a > b) ? a : b;
    msum = msum + m - mh[wp];
    mh[wp] = m;
    wp = (wp + 1) % WIN;
    mc++;
    if (mc == DEC) begin
      mc = 0;
      fallen = (mpeak > STEP) ? mpeak - STEP : 0;
      mpeak = (msum > fallen) ? msum : fallen;
      exp_q.push_back(lit_of(mpeak));
    end
  endtask

  // output monitor: checks R7, R8 per beat and R6 lit count per packet
  int beat = 0, plit = 0;
  bit seen_dark = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      beat = 0; plit = 0; seen_dark = 1'b0;
    end else if (out_valid && out_ready) begin
      automatic bit lit = (out_red | out_green | out_blue) != 8'd0;
      automatic logic [23:0] col = {out_red, out_green, out_blue};
      automatic logic [23:0] want;
      chk(out_addr == 8'(beat), "R8 address", out_addr, beat);
      chk(out_last == (beat == NL - 1), "R8 last flag", out_last, beat == NL - 1);
      if (!lit) seen_dark = 1'b1;
      else plit++;
      chk(!(lit && seen_dark), "R6 lit segments contiguous from 0", lit, 0);
      if (!lit) want = 24'h000000;
      else if (beat == NL - 1) want = 24'h400000;
      else if (beat == NL - 2) want = 24'h402000;
      else want = 24'h004000;
      chk(col == want, "R7 colour", col, want);
      if (beat == NL - 1) begin
        got_q.push_back(plit);
        if (cmp_en) begin
          if (exp_q.size() == 0) chk(1'b0, "R4 unexpected packet", plit, -1);
          else begin
            automatic int e = exp_q.pop_front();
            chk(plit == e, "R5 held level lit count", plit, e);
          end
        end
        beat = 0; plit = 0; seen_dark = 1'b0;
      end else beat++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "watchdog", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; cmp_en = 1'b1;
    for (int i = 0; i < WIN; i++) mh[i] = 0;
    wp = 0; mc = 0; msum = 0; mpeak = 0;
    exp_q.delete(); got_q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic send(input int l, input int r, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_left = 16'(l); in_right = 16'(r);
      model_push(l, r);
    end
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(posedge clk);
    #1 chk(exp_q.size() == 0, "R4 one packet per update", exp_q.size(), 0);
  endtask

  function automatic int last_got();
    return (got_q.size() == 0) ? -1 : got_q[got_q.size() - 1];
  endfunction

  task automatic t_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) chk(out_valid == 1'b0, "R10 no output in reset", out_valid, 0);
    do_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 idle after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
  endtask

  task automatic t_threshold_edge();
    do_reset();
    send(3959, 0, WIN);
    settle();
    chk(last_got() == 0, "R6 just below first threshold", last_got(), 0);
    do_reset();
    send(0, -3960, WIN);
    settle();
    chk(last_got() == 1, "R6 exactly on first threshold", last_got(), 1);
  endtask

  task automatic t_stereo_mix();
    do_reset();
    for (int i = 0; i < 16; i++) begin
      send(1000, -20000, 16);
      send(-26000, 500, 16);
    end
    settle();
    chk(in_ready == 1'b1, "R1 ready while streaming", in_ready, 1);
    chk(last_got() == 5, "R3 larger channel wins", last_got(), 5);
  endtask

  task automatic t_saturate_decay_rise();
    do_reset();
    send(5, -32768, WIN);
    settle();
    chk(last_got() == 8, "R2 most negative sample saturates", last_got(), 8);
    send(0, 0, 1000 * DEC);
    settle();
    chk(last_got() == 6, "R5 linear decay after 1000 updates", last_got(), 6);
    send(30000, -30000, WIN);
    settle();
    chk(last_got() == 7, "R5 immediate rise to new level", last_got(), 7);
  endtask

  task automatic t_backpressure();
    int first_e, last_e;
    do_reset();
    #1 out_ready = 1'b0;
    cmp_en = 1'b0;
    for (int i = 0; i < 10 * DEC; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_left = 16'(i * 50); in_right = 16'sd0;
      model_push(i * 50, 0);
    end
    @(posedge clk); #1 in_valid = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 beat held while stalled", out_valid, 1);
    chk(out_addr == 8'd0, "R9 first beat stays put", out_addr, 0);
    first_e = exp_q[0];
    last_e = exp_q[exp_q.size() - 1];
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (40) @(posedge clk);
    #1;
    chk(got_q.size() == 2, "R9 stale updates dropped", got_q.size(), 2);
    if (got_q.size() == 2) begin
      chk(got_q[0] == first_e, "R9 stalled packet content", got_q[0], first_e);
      chk(got_q[1] == last_e, "R9 newest level sent next", got_q[1], last_e);
    end
    cmp_en = 1'b1;
    exp_q.delete();
  endtask

  initial begin
    t_reset();
    t_threshold_edge();
    t_stereo_mix();
    t_saturate_decay_rise();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule